// File: doc/BRIEF.md
# ECC-Protected Flash Array Wrapper

This block stands between a CPU word port and a modelled flash storage array. Beside the array it keeps a check store that the CPU can neither read nor write. The CPU issues three commands: read, write and sector erase. Each 32-bit aligned group of four bytes has one check byte. The block computes that byte on every accepted write and stores it next to the data word. On a read it fetches the word and its check byte, repairs any single flipped data bit, and flags any double flip. All of this is invisible to the CPU apart from the status flags.

A check byte can be programmed only once between erases. Erased storage is all ones. The check byte of a programmed group always has its top bit at zero, so the block tests that bit to tell whether a group has already been written. A second write to a programmed group is rejected, and so is a partial or unaligned write. A sector erase is the only way to make a group writable again. The erase walks the sector one word per cycle and sets both the data and the check bytes to ones.

For testing, an `inj_mask` input XORs a mask onto the raw array output ahead of the decoder. This models cell upsets without touching the stored content. The controller is a four-state machine:

- `ST_IDLE` goes to `ST_FETCH` on a read or write, and to `ST_ERASE` on an erase.
- `ST_FETCH` moves on to `ST_CHECK` unconditionally.
- `ST_CHECK` decodes the fetched word, or programs it, and returns to `ST_IDLE`.
- `ST_ERASE` loops once per sector word and returns to `ST_IDLE` after the last word.

Top module: `ecc_flash_wrap`

## Requirements
- R1: An accepted aligned write with `cmd_be`=4'hF to a blank group returns `done` with `err_wr`=0. A later read returns the written word with `err_corr`=0 and `err_dbl`=0. `done` rises in the second cycle after the edge that accepted a read or write command. The flags and `rdata` change only on a `done` cycle.
- R2: If one data bit of a programmed group is flipped, a read returns the original word with `err_corr`=1 and `err_dbl`=0. This holds for every bit position 0 to 31.
- R3: If two data bits of a programmed group are flipped, a read returns the raw word as fetched with `err_dbl`=1 and `err_corr`=0. The two flags are never both high.
- R4: A write to a group that has been programmed since its last erase is rejected with `err_wr`=1. Both the data and the check byte are left unchanged.
- R5: A write with `cmd_addr[1:0]`≠0, or with `cmd_be`≠4'hF, is rejected with `err_wr`=1 and leaves the group unchanged.
- R6: A group whose check byte is erased reads as its raw word with no flag raised. An erased group reads 32'hFFFFFFFF.
- R7: Erase clears the whole sector selected by `cmd_addr[ADDR_W-1:12]`, data and check bytes alike, so that its groups read all ones and accept writes again. `done` rises SECTOR_BYTES/4 cycles after the accepting edge, and other sectors are untouched.
- R8: `busy` is high from the cycle after acceptance until the `done` cycle. Commands presented while `busy` is high are ignored. `done` is a single-cycle pulse. `cmd_op` encoding: 0 = read, 1 = write, 2 = erase, 3 = ignored.
- R9: After reset, `busy`, `done`, `err_corr`, `err_dbl` and `err_wr` are 0 and `rdata` is 0. Array content is undefined until its sector is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 read, 1 write, 2 sector erase |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 32 | Write data |
| cmd_be | input | 4 | Byte enables; all four required for a write |
| inj_mask | input | 32 | Fault mask XORed onto raw array data before decode |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result (corrected when possible) |
| err_corr | output | 1 | Single-bit error corrected on last read |
| err_dbl | output | 1 | Double-bit error detected on last read |
| err_wr | output | 1 | Last write rejected |

## Verification
A read or write completes two edges after the accepting edge. The bench counts exactly those edges and samples 1 ns after the second one. It also confirms that `done` is still low after the first edge, and that `busy` is already high at that point. An erase completes SECTOR_BYTES/4 edges after acceptance. The bench counts edges until `done` appears and compares that count with the word count of a sector. The fault mask is held from command issue through the decode cycle, so every expected read value is fixed before the command is sent.

// File: rtl/ecc_flash_pkg.sv
package ecc_flash_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 8;
    localparam int CW_LEN = 38;   // 32 data + 6 Hamming positions

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_ERASE
    } state_e;

    // Codeword position (1..38) of a data bit; power-of-two slots hold check bits
    function automatic logic [5:0] cw_pos(input int bit_idx);
        logic [5:0] p;
        int n;
        p = '0;
        n = 0;
        for (int q = 1; q <= CW_LEN; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == bit_idx) p = 6'(q);
                n++;
            end
        end
        return p;
    endfunction

    function automatic logic [5:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [5:0] s;
        s = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) s ^= cw_pos(i);
        end
        return s;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_flash_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [5:0] h;
    always_comb begin
        h   = ham_bits(data);
        // top bit held low marks the group as programmed
        chk = {1'b0, (^data) ^ (^h), h};
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_flash_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [CHK_W-1:0]  chk,
    output logic [DATA_W-1:0] data,
    output logic              corr,
    output logic              dbl
);
    logic [5:0] syn;
    logic       ovl;
    logic       blank;

    always_comb begin
        blank = (chk == {CHK_W{1'b1}});
        syn   = ham_bits(raw) ^ chk[5:0];
        ovl   = (^raw) ^ (^chk[6:0]);
        data  = raw;
        corr  = 1'b0;
        dbl   = 1'b0;
        if (!blank) begin
            if (ovl) begin
                if (syn > 6'(CW_LEN)) begin
                    dbl = 1'b1;
                end else begin
                    corr = 1'b1;
                    for (int i = 0; i < DATA_W; i++) begin
                        if (cw_pos(i) == syn) data[i] = ~raw[i];
                    end
                end
            end else if (syn != 6'd0) begin
                dbl = 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_store.sv
module flash_store
    import ecc_flash_pkg::*;
#(
    parameter int WORDS = 2048,
    localparam int WA_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wd,
    input  logic [CHK_W-1:0]  wchk,
    input  logic [WA_W-1:0]   raddr,
    output logic [DATA_W-1:0] qd,
    output logic [CHK_W-1:0]  qchk
);
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [CHK_W-1:0]  mem_c [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_d[waddr] <= wd;
            mem_c[waddr] <= wchk;
        end
        qd   <= mem_d[raddr];
        qchk <= mem_c[raddr];
    end
endmodule

// File: rtl/ecc_flash_wrap.sv
module ecc_flash_wrap
    import ecc_flash_pkg::*;
#(
    parameter int SECTORS      = 2,
    parameter int SECTOR_BYTES = 4096,
    localparam int ADDR_W      = $clog2(SECTORS * SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [3:0]        cmd_be,
    input  logic [DATA_W-1:0] inj_mask,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              err_corr,
    output logic              err_dbl,
    output logic              err_wr
);
    localparam int WORDS = SECTORS * SECTOR_BYTES / 4;
    localparam int WA_W  = ADDR_W - 2;
    localparam int SW    = SECTOR_BYTES / 4;
    localparam int SW_W  = $clog2(SW);

    state_e            state, state_nx;
    op_e               lat_op;
    logic [WA_W-1:0]   lat_wa;
    logic              lat_unal;
    logic [3:0]        lat_be;
    logic [DATA_W-1:0] lat_wd;
    logic [SW_W-1:0]   ctr;

    logic              mem_we;
    logic [WA_W-1:0]   mem_wa;
    logic [DATA_W-1:0] mem_wd;
    logic [CHK_W-1:0]  mem_wchk;
    logic [DATA_W-1:0] q_d;
    logic [CHK_W-1:0]  q_e;
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr, dec_dbl;
    logic              erasing, last_word, wr_ok;
    logic [WA_W-1:0]   er_addr;

    flash_store #(.WORDS(WORDS)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wd(mem_wd), .wchk(mem_wchk),
        .raddr(lat_wa), .qd(q_d), .qchk(q_e)
    );

    ecc_encoder u_enc (.data(lat_wd), .chk(enc_chk));

    ecc_decoder u_dec (
        .raw(q_d ^ inj_mask), .chk(q_e),
        .data(dec_data), .corr(dec_corr), .dbl(dec_dbl)
    );

    assign erasing   = (state == ST_ERASE);
    assign last_word = (ctr == SW_W'(SW - 1));
    assign er_addr   = (lat_wa & ~WA_W'(SW - 1)) | WA_W'(ctr);
    assign wr_ok     = !lat_unal && (lat_be == 4'hF) && q_e[CHK_W-1];
    assign busy      = (state != ST_IDLE);

    always_comb begin
        mem_we   = erasing || (state == ST_CHECK && lat_op == OP_WRITE && wr_ok);
        mem_wa   = erasing ? er_addr : lat_wa;
        mem_wd   = erasing ? {DATA_W{1'b1}} : lat_wd;
        mem_wchk = erasing ? {CHK_W{1'b1}} : enc_chk;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_READ || cmd_op == OP_WRITE) state_nx = ST_FETCH;
                    else if (cmd_op == OP_ERASE)                 state_nx = ST_ERASE;
                end
            end
            ST_FETCH: state_nx = ST_CHECK;
            ST_CHECK: state_nx = ST_IDLE;
            ST_ERASE: if (last_word) state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command capture and erase walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op   <= OP_NONE;
            lat_wa   <= '0;
            lat_unal <= 1'b0;
            lat_be   <= '0;
            lat_wd   <= '0;
            ctr      <= '0;
        end else if (state == ST_IDLE && cmd_valid) begin
            lat_op   <= op_e'(cmd_op);
            lat_wa   <= cmd_addr[ADDR_W-1:2];
            lat_unal <= (cmd_addr[1:0] != 2'b00);
            lat_be   <= cmd_be;
            lat_wd   <= cmd_wdata;
            ctr      <= '0;
        end else if (erasing) begin
            ctr      <= ctr + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rdata    <= '0;
            err_corr <= 1'b0;
            err_dbl  <= 1'b0;
            err_wr   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_CHECK: begin
                    done <= 1'b1;
                    if (lat_op == OP_READ) begin
                        rdata    <= dec_data;
                        err_corr <= dec_corr;
                        err_dbl  <= dec_dbl;
                        err_wr   <= 1'b0;
                    end else begin
                        err_corr <= 1'b0;
                        err_dbl  <= 1'b0;
                        err_wr   <= !wr_ok;
                    end
                end
                ST_ERASE: begin
                    if (last_word) begin
                        done     <= 1'b1;
                        err_corr <= 1'b0;
                        err_dbl  <= 1'b0;
                        err_wr   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc_flash_wrap_chk.sv
module ecc_flash_wrap_chk #(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] rdata,
    input logic          err_corr,
    input logic          err_dbl,
    input logic          err_wr,
    input logic          mem_we,
    input logic          erasing,
    input logic [CW-1:0] q_e
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_dbl));

    assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({err_corr, err_dbl, err_wr, rdata}));

    assert_prog_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !erasing) |-> (q_e == {CW{1'b1}}));

    assert_reject_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_wr) |-> !$past(mem_we));
endmodule

bind ecc_flash_wrap ecc_flash_wrap_chk #(.DW(DATA_W), .CW(CHK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
    .rdata(rdata), .err_corr(err_corr), .err_dbl(err_dbl), .err_wr(err_wr),
    .mem_we(mem_we), .erasing(erasing), .q_e(q_e)
);

// File: tb/ecc_flash_wrap_tb.sv
`timescale 1ns/1ps
module ecc_flash_wrap_tb;
    localparam int ADDR_W = 13;
    localparam int SW     = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [31:0]       cmd_wdata = '0;
    logic [3:0]        cmd_be = '0;
    logic [31:0]       inj_mask = '0;
    logic              busy, done, err_corr, err_dbl, err_wr;
    logic [31:0]       rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ecc_flash_wrap u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
        .inj_mask(inj_mask), .busy(busy), .done(done), .rdata(rdata),
        .err_corr(err_corr), .err_dbl(err_dbl), .err_wr(err_wr)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] mask;
        logic [31:0] exp;
        logic        corr;
        logic        dbl;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 2'd1, 16'h0000, 32'hA5A5_1234, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},          // R1
        '{4'd1, 2'd0, 16'h0000, 32'h0, 4'hF, 32'h0, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0},          // R1
        '{4'd2, 2'd0, 16'h0000, 32'h0, 4'hF, 32'h0000_0001, 32'hA5A5_1234, 1'b1, 1'b0, 1'b0},  // R2
        '{4'd2, 2'd0, 16'h0000, 32'h0, 4'hF, 32'h8000_0000, 32'hA5A5_1234, 1'b1, 1'b0, 1'b0},  // R2
        '{4'd3, 2'd0, 16'h0000, 32'h0, 4'hF, 32'h0001_0001, 32'hA5A4_1235, 1'b0, 1'b1, 1'b0},  // R3
        '{4'd4, 2'd1, 16'h0000, 32'h0000_0000, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},          // R4
        '{4'd4, 2'd0, 16'h0000, 32'h0, 4'hF, 32'h0, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0},          // R4
        '{4'd5, 2'd1, 16'h0006, 32'h1111_2222, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},          // R5
        '{4'd5, 2'd1, 16'h0004, 32'h3333_4444, 4'h3, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},          // R5
        '{4'd5, 2'd0, 16'h0004, 32'h0, 4'hF, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},          // R5
        '{4'd1, 2'd1, 16'h1000, 32'hFFFF_FFFF, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},          // R1
        '{4'd2, 2'd0, 16'h1000, 32'h0, 4'hF, 32'h0000_0080, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},  // R2
        '{4'd1, 2'd1, 16'h1FFC, 32'h0000_0000, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},          // R1
        '{4'd2, 2'd0, 16'h1FFC, 32'h0, 4'hF, 32'h0000_8000, 32'h0000_0000, 1'b1, 1'b0, 1'b0}   // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // read or write: done due 2 edges after the accepting edge
    task automatic rw_cmd(input logic [1:0] op, input logic [15:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, input logic [31:0] mask);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr[ADDR_W-1:0];
        cmd_wdata = wd; cmd_be = be; inj_mask = mask;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 busy after accept", 32'(busy), 32'd1);
        @(posedge clk); #1;
        check("R1 done not yet", 32'(done), 32'd0);
        @(posedge clk); #1;
        check("R1 done due", 32'(done), 32'd1);
    endtask

    task automatic erase_cmd(input logic [15:0] addr, input bit poke);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = addr[ADDR_W-1:0]; inj_mask = '0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (n < 3000) begin
            if (poke && n == 10) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 13'h0008;
                cmd_wdata = 32'h1234_5678; cmd_be = 4'hF;
            end
            @(posedge clk); n++; #1;
            if (poke && n == 11) cmd_valid = 1'b0;
            if (done) break;
        end
        check("R7 erase latency", 32'(n), 32'(SW));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 busy", 32'(busy), 32'd0);
        check("R9 done", 32'(done), 32'd0);
        check("R9 flags", {29'd0, err_corr, err_dbl, err_wr}, 32'd0);
        check("R9 rdata", rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        erase_cmd(16'h0000, 1'b0);   // R7
        erase_cmd(16'h1000, 1'b0);   // R7
        rw_cmd(2'd0, 16'h0000, 32'h0, 4'hF, 32'h0);
        check("R6 blank read", rdata, 32'hFFFF_FFFF);
        check("R6 blank flags", {29'd0, err_corr, err_dbl, err_wr}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d vector %0d", v.req, i);
            rw_cmd(v.op, v.addr, v.wd, v.be, v.mask);
            if (v.op == 2'd1) begin
                check({tg, " err_wr"}, 32'(err_wr), 32'(v.err));
            end else begin
                check({tg, " rdata"}, rdata, v.exp);
                check({tg, " corr"}, 32'(err_corr), 32'(v.corr));
                check({tg, " dbl"}, 32'(err_dbl), 32'(v.dbl));
            end
        end

        // R8: write poked during erase is ignored
        erase_cmd(16'h0000, 1'b1);
        rw_cmd(2'd0, 16'h0008, 32'h0, 4'hF, 32'h0);
        check("R8 ignored while busy", rdata, 32'hFFFF_FFFF);
        // R7: sector cleared and writable again, other sector kept
        rw_cmd(2'd0, 16'h0000, 32'h0, 4'hF, 32'h0);
        check("R7 cleared", rdata, 32'hFFFF_FFFF);
        rw_cmd(2'd1, 16'h0000, 32'h5A5A_0F0F, 4'hF, 32'h0);
        check("R7 rewritable", 32'(err_wr), 32'd0);
        rw_cmd(2'd0, 16'h0000, 32'h0, 4'hF, 32'h0);
        check("R7 readback", rdata, 32'h5A5A_0F0F);
        rw_cmd(2'd0, 16'h1FFC, 32'h0, 4'hF, 32'h0);
        check("R7 other sector kept", rdata, 32'h0000_0000);
        check("R7 other sector flags", {29'd0, err_corr, err_dbl, err_wr}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule